// File: doc/BRIEF.md
# Multi-Cycle Shared-Resource Processor Datapath

This block is the 32-bit datapath of a processor that spends several clock cycles on each instruction. One memory port carries both instruction fetches and data accesses. One ALU computes the PC increment, branch targets, load/store addresses and arithmetic results. A register file with two read ports and one write port supplies operands. Partial results pass from one step of an instruction to the next through internal holding registers: instruction, memory data, operand A, operand B and ALU result.

A separate sequencer drives every multiplexer select and write enable through plain control pins. The datapath returns the opcode field, the function field and the live ALU zero flag, which the sequencer uses to choose its next state. The memory port is plain and has no handshake. The address, write data and the two enables are valid during the cycle they are driven. The memory must return read data in that same cycle, and the datapath captures it at the closing clock edge. There is no back-pressure: a slow memory is handled by the sequencer holding all write enables low until the data is ready.

Top module: `mcdp_core`

## Requirements
- R1: After the active-low asynchronous reset, the PC is 0. The instruction, A, B, memory data and ALU result registers and all register-file entries are 0. So `opcode` and `funct` read 0, and with all controls low `mem_addr` is 0 and `alu_zero` is 1.
- R2: `mem_addr` is the PC when `ctl_addr_sel`=0 and the registered ALU result when it is 1. `mem_re` follows `ctl_mem_rd`, `mem_we` follows `ctl_mem_wr`, and `mem_wdata` is operand register B.
- R3: The instruction register loads `mem_rdata` at a clock edge only when `ctl_ir_we`=1, and otherwise holds its value. `opcode` is instruction bits [31:26] and `funct` is bits [5:0].
- R4: Register read ports are addressed by instruction bits [25:21] (to A) and [20:16] (to B). The write address is bits [20:16] when `ctl_wr_dst_sel`=0 and bits [15:11] when it is 1. A register is written only when `ctl_rf_we`=1.
- R5: Register write data is the registered ALU result when `ctl_wb_sel`=0 and the memory data register when it is 1.
- R6: Register 0 always reads as zero, and writes to it are discarded.
- R7: The first ALU operand is the PC when `ctl_opa_sel`=0 and register A when it is 1.
- R8: The second ALU operand is set by `ctl_opb_sel`: 00 selects B, 01 the constant 4, 10 the sign-extended bits [15:0], and 11 the sign-extended bits [15:0] shifted left by 2.
- R9: `ctl_aluop` 00 and 11 select add, and 01 selects subtract. Code 10 decodes `funct`: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0), and any other value add.
- R10: `alu_zero` is 1 exactly when the live ALU result in the current cycle is zero.
- R11: The next PC is set by `ctl_pc_src`: 01 selects the registered ALU result, 10 the jump address {PC[31:28], IR[25:0], 2'b00}, and 00 or 11 the live ALU result.
- R12: The PC loads at a clock edge when `ctl_pc_we`=1, or when `ctl_pc_we_cond`=1 and `alu_zero`=1. Otherwise it holds.
- R13: The A, B, memory data and ALU result registers load on every clock edge, with no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_pc_we | input | 1 | Unconditional PC write |
| ctl_pc_we_cond | input | 1 | PC write qualified by ALU zero |
| ctl_addr_sel | input | 1 | Memory address select: 0 PC, 1 ALU result register |
| ctl_mem_rd | input | 1 | Memory read request |
| ctl_mem_wr | input | 1 | Memory write request |
| ctl_ir_we | input | 1 | Instruction register load |
| ctl_wr_dst_sel | input | 1 | Write register select: 0 bits [20:16], 1 bits [15:11] |
| ctl_rf_we | input | 1 | Register file write |
| ctl_wb_sel | input | 1 | Write data select: 0 ALU result register, 1 memory data register |
| ctl_opa_sel | input | 1 | First ALU operand: 0 PC, 1 A |
| ctl_opb_sel | input | 2 | Second ALU operand select |
| ctl_aluop | input | 2 | ALU operation class |
| ctl_pc_src | input | 2 | Next-PC select |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid in the request cycle |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| opcode | output | 6 | Instruction bits [31:26] |
| funct | output | 6 | Instruction bits [5:0] |
| alu_zero | output | 1 | Live ALU result is zero |

## Verification
The memory port signals and `alu_zero` are combinational on the current holding registers and controls. They are therefore due in the same cycle the controls are driven. A register-file write or a PC update first shows one cycle later: the PC through `mem_addr` at the next fetch, and a register through `mem_wdata` two cycles after a store reads it (one edge into B, then the store-access cycle). The bench drives controls just after the falling edge. It queues each expected value for the cycle its step is driven and compares shortly before the next rising edge. Because every expectation is queued against the step whose state it reflects, each one lands on the cycle where the value is due.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;
  localparam int XLEN   = 32;
  localparam int INSN_W = 32;
  localparam int RADDR_W = 5;

  typedef enum logic [2:0] {
    ALU_AND = 3'd0,
    ALU_OR  = 3'd1,
    ALU_ADD = 3'd2,
    ALU_SUB = 3'd6,
    ALU_SLT = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    OPB_REG   = 2'b00,
    OPB_FOUR  = 2'b01,
    OPB_IMM   = 2'b10,
    OPB_IMMSH = 2'b11
  } opb_sel_e;

  typedef enum logic [1:0] {
    PCS_ALU    = 2'b00,
    PCS_ALUREG = 2'b01,
    PCS_JUMP   = 2'b10,
    PCS_ALT    = 2'b11
  } pc_src_e;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;
endpackage

// File: rtl/mcdp_regfile.sv
module mcdp_regfile #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [DW-1:0] rd1,
  output logic [DW-1:0] rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] rows [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_row
    if (g == 0) begin : g_zero
      // entry 0 is hard-wired, writes to it vanish (R6)
      assign rows[g] = '0;
    end else begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (we && (wa == AW'(g))) q <= wd;
      end
      assign rows[g] = q;
    end
  end

  assign rd1 = rows[ra1];
  assign rd2 = rows[ra2];
endmodule

// File: rtl/mcdp_alu_ctl.sv
module mcdp_alu_ctl
  import mcdp_pkg::*;
(
  input  logic [1:0] aluop,
  input  logic [5:0] fn,
  output alu_op_e    op
);
  always_comb begin
    unique case (aluop)
      2'b01: op = ALU_SUB;
      2'b10: begin
        unique case (fn)
          FN_SUB:  op = ALU_SUB;
          FN_AND:  op = ALU_AND;
          FN_OR:   op = ALU_OR;
          FN_SLT:  op = ALU_SLT;
          default: op = ALU_ADD;   // FN_ADD and unknown codes
        endcase
      end
      default: op = ALU_ADD;       // 00 and 11
    endcase
  end
endmodule

// File: rtl/mcdp_alu.sv
module mcdp_alu
  import mcdp_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_op_e       op,
  output logic [DW-1:0] y,
  output logic          zero
);
  logic [DW-1:0] diff;
  logic          lt;

  assign diff = a - b;
  assign lt   = $signed(a) < $signed(b);

  always_comb begin
    unique case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(DW-1){1'b0}}, lt};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mcdp_core.sv
module mcdp_core
  import mcdp_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_pc_we,
  input  logic            ctl_pc_we_cond,
  input  logic            ctl_addr_sel,
  input  logic            ctl_mem_rd,
  input  logic            ctl_mem_wr,
  input  logic            ctl_ir_we,
  input  logic            ctl_wr_dst_sel,
  input  logic            ctl_rf_we,
  input  logic            ctl_wb_sel,
  input  logic            ctl_opa_sel,
  input  logic [1:0]      ctl_opb_sel,
  input  logic [1:0]      ctl_aluop,
  input  logic [1:0]      ctl_pc_src,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            mem_re,
  output logic            mem_we,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  output logic            alu_zero
);
  localparam int IMM_W  = 16;
  localparam int JMP_W  = 26;
  localparam int PCHI_W = XLEN - JMP_W - 2;

  // holding registers
  logic [XLEN-1:0]   pc_q;
  logic [INSN_W-1:0] ir_q;
  logic [XLEN-1:0]   mdr_q, a_q, b_q, alu_out_q;

  // combinational nets
  logic [XLEN-1:0]    rf_rd1, rf_rd2, rf_wd;
  logic [RADDR_W-1:0] rf_wa;
  logic [XLEN-1:0]    imm_sx, imm_sh, jump_tgt;
  logic [XLEN-1:0]    opa, opb, alu_y, pc_nxt;
  logic               pc_en;
  alu_op_e            alu_op;

  // instruction register, written only on request (R3)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ir_q <= '0;
    else if (ctl_ir_we) ir_q <= mem_rdata;
  end

  // free-running step registers (R13)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdr_q     <= '0;
      a_q       <= '0;
      b_q       <= '0;
      alu_out_q <= '0;
    end else begin
      mdr_q     <= mem_rdata;
      a_q       <= rf_rd1;
      b_q       <= rf_rd2;
      alu_out_q <= alu_y;
    end
  end

  // program counter (R11, R12)
  assign pc_en = ctl_pc_we | (ctl_pc_we_cond & alu_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= RESET_PC;
    else if (pc_en) pc_q <= pc_nxt;
  end

  assign jump_tgt = {pc_q[XLEN-1 -: PCHI_W], ir_q[JMP_W-1:0], 2'b00};

  always_comb begin
    unique case (pc_src_e'(ctl_pc_src))
      PCS_ALUREG: pc_nxt = alu_out_q;
      PCS_JUMP:   pc_nxt = jump_tgt;
      default:    pc_nxt = alu_y;
    endcase
  end

  // register file addressing and write-back (R4, R5)
  assign rf_wa = ctl_wr_dst_sel ? ir_q[15:11] : ir_q[20:16];
  assign rf_wd = ctl_wb_sel ? mdr_q : alu_out_q;

  mcdp_regfile #(
    .DW (XLEN),
    .AW (RADDR_W)
  ) i_regfile (
    .clk   (clk),
    .rst_n (rst_n),
    .ra1   (ir_q[25:21]),
    .ra2   (ir_q[20:16]),
    .rd1   (rf_rd1),
    .rd2   (rf_rd2),
    .we    (ctl_rf_we),
    .wa    (rf_wa),
    .wd    (rf_wd)
  );

  // operand selection (R7, R8)
  assign imm_sx = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign imm_sh = {imm_sx[XLEN-3:0], 2'b00};
  assign opa    = ctl_opa_sel ? a_q : pc_q;

  always_comb begin
    unique case (opb_sel_e'(ctl_opb_sel))
      OPB_REG:   opb = b_q;
      OPB_FOUR:  opb = XLEN'(4);
      OPB_IMM:   opb = imm_sx;
      default:   opb = imm_sh;
    endcase
  end

  // ALU and its control decoder (R9, R10)
  mcdp_alu_ctl i_alu_ctl (
    .aluop (ctl_aluop),
    .fn    (ir_q[5:0]),
    .op    (alu_op)
  );

  mcdp_alu #(
    .DW (XLEN)
  ) i_alu (
    .a    (opa),
    .b    (opb),
    .op   (alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // memory port and decoded fields (R2, R3)
  assign mem_addr  = ctl_addr_sel ? alu_out_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_re    = ctl_mem_rd;
  assign mem_we    = ctl_mem_wr;
  assign opcode    = ir_q[31:26];
  assign funct     = ir_q[5:0];
endmodule

// File: rtl/mcdp_core_chk.sv
module mcdp_core_chk
  import mcdp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_pc_we,
  input logic              ctl_pc_we_cond,
  input logic              ctl_ir_we,
  input logic [1:0]        ctl_pc_src,
  input logic              alu_zero,
  input logic [XLEN-1:0]   mem_rdata,
  input logic [XLEN-1:0]   pc_q,
  input logic [INSN_W-1:0] ir_q,
  input logic [XLEN-1:0]   alu_out_q,
  input logic [XLEN-1:0]   alu_y
);
  p_ir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_ir_we |=> $stable(ir_q));

  p_ir_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_ir_we |=> (ir_q == $past(mem_rdata)));

  p_pc_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_pc_we || (ctl_pc_we_cond && alu_zero)) |=> $stable(pc_q));

  p_pc_live_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_pc_we && (ctl_pc_src == 2'b00)) |=> (pc_q == $past(alu_y)));

  p_pc_branch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_pc_we_cond && alu_zero && (ctl_pc_src == 2'b01)) |=> (pc_q == $past(alu_out_q)));

  p_pc_jump_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_pc_we && (ctl_pc_src == 2'b10))
      |=> (pc_q == {$past(pc_q[31:28]), $past(ir_q[25:0]), 2'b00}));

  p_aluout_r13: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (alu_out_q == $past(alu_y)));
endmodule

bind mcdp_core mcdp_core_chk i_mcdp_core_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ctl_pc_we      (ctl_pc_we),
  .ctl_pc_we_cond (ctl_pc_we_cond),
  .ctl_ir_we      (ctl_ir_we),
  .ctl_pc_src     (ctl_pc_src),
  .alu_zero       (alu_zero),
  .mem_rdata      (mem_rdata),
  .pc_q           (pc_q),
  .ir_q           (ir_q),
  .alu_out_q      (alu_out_q),
  .alu_y          (alu_y)
);

// File: tb/test_mcdp_core.sv
module test_mcdp_core;
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [2:0] K_ADDR = 3'd0, K_WDATA = 3'd1, K_ZERO = 3'd2,
                         K_OP = 3'd3, K_FN = 3'd4, K_RE = 3'd5, K_WE = 3'd6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pc_we, pc_we_cond, addr_sel, mem_rd, mem_wr, ir_we;
  logic wr_dst_sel, rf_we, wb_sel, opa_sel;
  logic [1:0] opb_sel, aluop, pc_src;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic mem_re, mem_we;
  logic [5:0] opcode, funct;
  logic alu_zero;

  always #10 clk = ~clk;   // 50 MHz

  mcdp_core i_mcdp_core (
    .clk(clk), .rst_n(rst_n),
    .ctl_pc_we(pc_we), .ctl_pc_we_cond(pc_we_cond), .ctl_addr_sel(addr_sel),
    .ctl_mem_rd(mem_rd), .ctl_mem_wr(mem_wr), .ctl_ir_we(ir_we),
    .ctl_wr_dst_sel(wr_dst_sel), .ctl_rf_we(rf_we), .ctl_wb_sel(wb_sel),
    .ctl_opa_sel(opa_sel), .ctl_opb_sel(opb_sel), .ctl_aluop(aluop),
    .ctl_pc_src(pc_src),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_re(mem_re), .mem_we(mem_we),
    .opcode(opcode), .funct(funct), .alu_zero(alu_zero)
  );

  // bench memory: same-cycle read, write at the rising edge
  logic [31:0] mem [64];
  assign mem_rdata = mem[mem_addr[7:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:2]] = mem_wdata;

  // scoreboard
  typedef struct packed {
    logic [2:0]  kind;
    logic [3:0]  req;
    logic [31:0] val;
  } exp_t;
  exp_t sb_q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic expect_val(input logic [2:0] k, input logic [3:0] r, input logic [31:0] v);
    exp_t e;
    e.kind = k; e.req = r; e.val = v;
    sb_q.push_back(e);
  endtask

  // monitor: compares just before each rising edge
  initial forever begin
    @(negedge clk);
    #8;
    while (sb_q.size() > 0) begin
      exp_t e;
      logic [31:0] act;
      e = sb_q.pop_front();
      case (e.kind)
        K_ADDR:  act = mem_addr;
        K_WDATA: act = mem_wdata;
        K_ZERO:  act = {31'd0, alu_zero};
        K_OP:    act = {26'd0, opcode};
        K_FN:    act = {26'd0, funct};
        K_RE:    act = {31'd0, mem_re};
        default: act = {31'd0, mem_we};
      endcase
      n_chk++;
      if (act !== e.val) begin
        n_fail++;
        $display("FAIL R%0d (kind %0d): actual %h expected %h", e.req, e.kind, act, e.val);
      end
    end
  end

  // independent model state
  logic [31:0] xrf [32];
  logic [31:0] xpc;
  logic [31:0] xtgt;

  function automatic logic [31:0] sx(input logic [15:0] i);
    return {{16{i[15]}}, i};
  endfunction

  function automatic logic [31:0] ref_alu(input logic [31:0] a, input logic [31:0] b,
                                          input logic [5:0] fn);
    case (fn)
      6'h22:   return a - b;
      6'h24:   return a & b;
      6'h25:   return a | b;
      6'h2A:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return a + b;
    endcase
  endfunction

  task automatic step_begin();
    @(negedge clk);
    #1;
    {pc_we, pc_we_cond, addr_sel, mem_rd, mem_wr, ir_we} = '0;
    {wr_dst_sel, rf_we, wb_sel, opa_sel} = '0;
    {opb_sel, aluop, pc_src} = '0;
  endtask

  task automatic do_fetch(input logic [31:0] insn);
    step_begin();
    mem[xpc[7:2]] = insn;
    addr_sel = 1'b0; mem_rd = 1'b1; ir_we = 1'b1;
    opa_sel = 1'b0; opb_sel = 2'b01; aluop = 2'b00; pc_we = 1'b1; pc_src = 2'b00;
    expect_val(K_ADDR, 4'd2, xpc);     // R2: fetch addresses memory with PC; R11/R12 PC path
    expect_val(K_RE, 4'd2, 32'd1);     // R2
    xpc = xpc + 32'd4;                 // R8 constant 4, R7 PC operand
  endtask

  task automatic do_decode(input logic [31:0] insn);
    step_begin();
    opa_sel = 1'b0; opb_sel = 2'b11; aluop = 2'b00;
    expect_val(K_OP, 4'd3, {26'd0, insn[31:26]});   // R3
    expect_val(K_FN, 4'd3, {26'd0, insn[5:0]});     // R3
    xtgt = xpc + (sx(insn[15:0]) << 2);
  endtask

  task automatic do_rtype(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd,
                          input logic [5:0] fn, input bit wr);
    logic [31:0] insn, res;
    insn = {6'd0, rs, rt, rd, 5'd0, fn};
    do_fetch(insn);
    do_decode(insn);
    res = ref_alu(xrf[rs], xrf[rt], fn);
    step_begin();
    opa_sel = 1'b1; opb_sel = 2'b00; aluop = 2'b10;
    expect_val(K_ZERO, 4'd10, {31'd0, res == 32'd0});   // R10 with R9 decode
    step_begin();
    wr_dst_sel = 1'b1; rf_we = wr; wb_sel = 1'b0;       // R4 rd destination, R5 ALU path
    if (wr && rd != 5'd0) xrf[rd] = res;
  endtask

  task automatic do_lw(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm);
    logic [31:0] insn, ea;
    insn = {6'd35, rs, rt, imm};
    do_fetch(insn);
    do_decode(insn);
    ea = xrf[rs] + sx(imm);
    step_begin();
    opa_sel = 1'b1; opb_sel = 2'b10; aluop = 2'b00;
    step_begin();
    addr_sel = 1'b1; mem_rd = 1'b1;
    expect_val(K_ADDR, 4'd13, ea);     // R13 ALU result register, R8 immediate, R2
    step_begin();
    wr_dst_sel = 1'b0; rf_we = 1'b1; wb_sel = 1'b1;   // R5 memory data path
    expect_val(K_OP, 4'd3, 32'd35);    // R3: IR unchanged by the data read
    if (rt != 5'd0) xrf[rt] = mem[ea[7:2]];
  endtask

  task automatic do_sw(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm,
                       input logic [3:0] rq);
    logic [31:0] insn, ea;
    insn = {6'd43, rs, rt, imm};
    do_fetch(insn);
    do_decode(insn);
    ea = xrf[rs] + sx(imm);
    step_begin();
    opa_sel = 1'b1; opb_sel = 2'b10; aluop = 2'b00;
    step_begin();
    addr_sel = 1'b1; mem_wr = 1'b1;
    expect_val(K_ADDR, 4'd2, ea);      // R2
    expect_val(K_WE, 4'd2, 32'd1);     // R2
    expect_val(K_WDATA, rq, xrf[rt]);  // register content for the tagged requirement
  endtask

  task automatic do_beq(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] off);
    logic [31:0] insn;
    insn = {6'd4, rs, rt, off};
    do_fetch(insn);
    do_decode(insn);
    step_begin();
    opa_sel = 1'b1; opb_sel = 2'b00; aluop = 2'b01; pc_we_cond = 1'b1; pc_src = 2'b01;
    expect_val(K_ZERO, 4'd10, {31'd0, xrf[rs] == xrf[rt]});   // R10
    if (xrf[rs] == xrf[rt]) xpc = xtgt;                        // R12 conditional write
  endtask

  task automatic do_jump(input logic [25:0] tgt);
    logic [31:0] insn;
    insn = {6'd2, tgt};
    do_fetch(insn);
    do_decode(insn);
    step_begin();
    pc_we = 1'b1; pc_src = 2'b10;
    xpc = {xpc[31:28], tgt, 2'b00};    // R11 jump address
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    for (int i = 0; i < 32; i++) xrf[i] = 32'd0;
    mem[40] = 32'h0000_0005;
    mem[41] = 32'hFFFF_FFFD;
    mem[42] = 32'h0000_0005;
    xpc = 32'd0;
    xtgt = 32'd0;
    {pc_we, pc_we_cond, addr_sel, mem_rd, mem_wr, ir_we} = '0;
    {wr_dst_sel, rf_we, wb_sel, opa_sel} = '0;
    {opb_sel, aluop, pc_src} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    step_begin();
    expect_val(K_ADDR, 4'd1, 32'd0);
    expect_val(K_OP, 4'd1, 32'd0);
    expect_val(K_FN, 4'd1, 32'd0);
    expect_val(K_RE, 4'd1, 32'd0);
    expect_val(K_WE, 4'd1, 32'd0);
    expect_val(K_ZERO, 4'd1, 32'd1);

    // loads (R5, R13)
    do_lw(5'd0, 5'd1, 16'd160);
    do_lw(5'd0, 5'd2, 16'd164);
    do_lw(5'd0, 5'd3, 16'd168);

    // ALU operations (R9, R10)
    do_rtype(5'd1, 5'd2, 5'd4, 6'h20, 1'b1);    // add
    do_rtype(5'd1, 5'd3, 5'd5, 6'h22, 1'b1);    // sub -> zero
    do_rtype(5'd1, 5'd2, 5'd6, 6'h24, 1'b1);    // and
    do_rtype(5'd1, 5'd2, 5'd7, 6'h25, 1'b1);    // or
    do_rtype(5'd2, 5'd1, 5'd8, 6'h2A, 1'b1);    // slt true (signed)
    do_rtype(5'd1, 5'd2, 5'd9, 6'h2A, 1'b1);    // slt false
    do_rtype(5'd1, 5'd3, 5'd10, 6'h27, 1'b1);   // unknown funct -> add
    do_rtype(5'd1, 5'd1, 5'd0, 6'h20, 1'b1);    // R6 write to r0 dropped
    do_rtype(5'd2, 5'd2, 5'd1, 6'h20, 1'b0);    // R4 no write without enable
    do_lw(5'd0, 5'd0, 16'd160);                 // R6 load into r0 dropped

    // observe results through stores
    do_sw(5'd0, 5'd4, 16'd192, 4'd9);    // R9 add = 2
    do_sw(5'd0, 5'd5, 16'd196, 4'd9);    // R9 sub = 0
    do_sw(5'd0, 5'd6, 16'd200, 4'd9);    // R9 and
    do_sw(5'd0, 5'd7, 16'd204, 4'd9);    // R9 or
    do_sw(5'd0, 5'd8, 16'd208, 4'd9);    // R9 slt = 1
    do_sw(5'd0, 5'd9, 16'd212, 4'd9);    // R9 slt = 0
    do_sw(5'd0, 5'd10, 16'd216, 4'd9);   // R9 default add
    do_sw(5'd0, 5'd0, 16'd220, 4'd6);    // R6 r0 reads zero
    do_sw(5'd0, 5'd1, 16'd224, 4'd4);    // R4 r1 untouched with rf_we low
    do_sw(5'd0, 5'd2, 16'd228, 4'd4);    // R4 rt not clobbered by rd write
    do_sw(5'd3, 5'd1, 16'hFFFC, 4'd8);   // R8 negative sign-extended offset
    do_lw(5'd0, 5'd11, 16'd192);         // R5 read back a stored value
    do_sw(5'd0, 5'd11, 16'd232, 4'd5);   // R5

    // branches and jumps (R11, R12)
    do_beq(5'd1, 5'd3, 16'd2);           // taken forward
    do_beq(5'd1, 5'd2, 16'd5);           // not taken
    do_beq(5'd3, 5'd1, 16'hFFFC);        // taken backward
    do_jump(26'h000_000C);
    do_lw(5'd0, 5'd12, 16'd164);         // fetch at jump target checks PC
    do_jump(26'h200_0010);
    do_sw(5'd0, 5'd12, 16'd236, 4'd11);  // R11 fetch from high jump address

    step_begin();
    @(negedge clk);
    #9;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // watchdog
  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule